// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request source and an asynchronous static RAM. The RAM is 64K words of 4 bits and has separate data-in and data-out pins. The requester offers one read or one write at a time on a valid/ready handshake. The sequencer then drives the RAM's active-low chip select, its address, its active-low write-enable pulse and its write data. Every interval is spaced out in whole clock cycles. Each interval length is derived at elaboration from a nanosecond limit (in picoseconds), rounded up against the clock period, with a floor of one cycle.

A write passes through `S_WR_SETUP`, then `S_WR_PULSE`, then `S_WR_HOLD`, then back to `S_IDLE`:
- In `S_WR_SETUP`, chip select and address are driven while write enable stays high.
- In `S_WR_PULSE`, write enable is low. The write data is launched on the same edge that write enable falls, because the RAM only needs data set up to the rising edge of the pulse.
- In `S_WR_HOLD`, address, select and data are kept unchanged after the rising edge.

A read normally goes from `S_IDLE` straight to `S_RD_ACCESS`, then `S_RD_HOLD`, then `S_IDLE`. The RAM output is captured when the access count runs out, and it is returned with a one-cycle response strobe. If the read targets the address of the last write while that write's recovery window is still open, the read is routed `S_IDLE` to `S_RD_WAIT` instead. It stays there with chip select high until the window closes, and only then moves to `S_RD_ACCESS`.

Top module: `asram_seq`

## Requirements
- R1: During and after reset, with no request, mem_cs_n=1, mem_we_n=1, rsp_valid=0 and req_ready=1.
- R2: req_ready is high only in the idle state. It falls on the cycle after a request is accepted and stays low until the cycle ends. Address, write flag and data are captured at acceptance, so later changes on the request inputs are ignored.
- R3: For a write, mem_cs_n is low and mem_addr holds the request address for at least SETUP_C cycles (at least one) before mem_we_n falls. Both stay unchanged while mem_we_n is low and for HOLD_C cycles after it rises.
- R4: mem_we_n is low for exactly PULSE_C consecutive cycles. PULSE_C is the larger of the rounded-up pulse width and the rounded-up data setup time.
- R5: mem_din takes the write data on the edge where mem_we_n falls and stays unchanged until the write cycle ends. It is therefore valid for at least the data setup time before mem_we_n rises, and the RAM stores the requested value.
- R6: A read with no recovery conflict drives mem_cs_n low and mem_addr on the acceptance edge. It samples mem_dout ACCESS_C edges later, and rsp_valid is high for exactly one cycle with that value on rsp_rdata.
- R7: A read whose address equals the last write's address, accepted fewer than RECOV_C cycles after that write's mem_we_n rose, keeps mem_cs_n high. Select is not driven until RECOV_C+1 cycles after the rise.
- R8: A read to a different address from the last write is never delayed by the recovery window.
- R9: mem_we_n is low only while mem_cs_n is low.
- R10: mem_cs_n is high whenever the sequencer is idle. The next request can be accepted one cycle after the hold interval ends: a write is busy SETUP_C+PULSE_C+HOLD_C cycles, and a read is busy for its access time (plus any recovery wait) plus HOLD_C cycles.
- R11: A write never produces rsp_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Read data |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_addr | output | ADDR_W | RAM address |
| mem_din | output | DATA_W | RAM write data |
| mem_dout | input | DATA_W | RAM read data |

## Verification
The hardest situation to reach from the ports is the recovery conflict. It requires a read to the just-written address, accepted on the first idle cycle after the write's hold interval, while the recovery count is still running. The bench's driver issues each request on the same cycle that the previous one releases ready, so a write followed directly by a read of the same word lands inside the window. The RAM model in the bench returns unknown data for any sample taken before both the access time and the recovery time have elapsed, so a read that skips the wait returns corrupt data, and its latency is also checked against the expected longer value.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_SETUP,
        S_WR_PULSE,
        S_WR_HOLD,
        S_RD_WAIT,
        S_RD_ACCESS,
        S_RD_HOLD
    } seq_state_e;

    // Whole clock cycles covering a time in picoseconds, never below one.
    function automatic int unsigned cyc_of(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_interval.sv
`timescale 1ns/1ps
module asram_interval #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

    // A zero length would wrap the count and stretch a write pulse (R4).
    p_len_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));

endmodule

// File: rtl/asram_recovery.sv
`timescale 1ns/1ps
module asram_recovery #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned RECOV_C = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_end,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              hazard
);
    localparam int unsigned REC_W = $clog2(RECOV_C + 1);

    logic [REC_W-1:0]  rec_cnt;
    logic [ADDR_W-1:0] rec_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_cnt  <= '0;
            rec_addr <= '0;
        end else if (wr_end) begin
            rec_cnt  <= REC_W'(RECOV_C);
            rec_addr <= wr_addr;
        end else if (rec_cnt != '0) begin
            rec_cnt <= rec_cnt - 1'b1;
        end
    end

    assign hazard = (rec_cnt != '0) && (chk_addr == rec_addr);

    // After the window opens, the count only shrinks until a new write reloads it (R7).
    p_window_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rec_cnt) != '0 && !$past(wr_end)) |-> (rec_cnt < $past(rec_cnt)));

endmodule

// File: rtl/asram_capture.sv
`timescale 1ns/1ps
module asram_capture #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cap_en;
            if (cap_en) begin
                rsp_rdata <= cap_data;
            end
        end
    end

    p_rsp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 4,
    parameter int unsigned T_CLK_PS    = 5000,
    parameter int unsigned T_ASET_PS   = 0,
    parameter int unsigned T_PULSE_PS  = 5000,
    parameter int unsigned T_DSET_PS   = 5000,
    parameter int unsigned T_HOLD_PS   = 2000,
    parameter int unsigned T_ACC_PS    = 7000,
    parameter int unsigned T_RECOV_PS  = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_din,
    input  logic [DATA_W-1:0] mem_dout
);
    localparam int unsigned SETUP_C = cyc_of(T_ASET_PS, T_CLK_PS);
    localparam int unsigned PULSE_C = max2(cyc_of(T_PULSE_PS, T_CLK_PS),
                                           cyc_of(T_DSET_PS, T_CLK_PS));
    localparam int unsigned HOLD_C  = cyc_of(T_HOLD_PS, T_CLK_PS);
    localparam int unsigned ACC_C   = cyc_of(T_ACC_PS, T_CLK_PS);
    localparam int unsigned RECOV_C = cyc_of(T_RECOV_PS, T_CLK_PS);
    localparam int unsigned MAX_C   = max2(max2(SETUP_C, PULSE_C), max2(HOLD_C, ACC_C));
    localparam int unsigned TMR_W   = $clog2(MAX_C + 1);
    localparam int unsigned PCHK_W  = $clog2(PULSE_C + 2);

    seq_state_e state, nxt;

    logic              accept;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_len;
    logic              tmr_last;
    logic              rec_hazard;
    logic              wr_end;
    logic              cap_en;
    logic [ADDR_W-1:0] chk_addr;

    logic              rq_write;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] rq_wdata;

    assign req_ready = (state == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign chk_addr  = (state == S_IDLE) ? req_addr : rq_addr;
    assign wr_end    = (state == S_WR_PULSE) && (nxt == S_WR_HOLD);
    assign cap_en    = (state == S_RD_ACCESS) && tmr_last;
    assign tmr_load  = (nxt != state);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        nxt = S_WR_SETUP;
                    end else if (rec_hazard) begin
                        nxt = S_RD_WAIT;
                    end else begin
                        nxt = S_RD_ACCESS;
                    end
                end
            end
            S_WR_SETUP:  if (tmr_last) nxt = S_WR_PULSE;
            S_WR_PULSE:  if (tmr_last) nxt = S_WR_HOLD;
            S_WR_HOLD:   if (tmr_last) nxt = S_IDLE;
            S_RD_WAIT:   if (!rec_hazard) nxt = S_RD_ACCESS;
            S_RD_ACCESS: if (tmr_last) nxt = S_RD_HOLD;
            S_RD_HOLD:   if (tmr_last) nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    // Interval length for the state being entered
    always_comb begin
        unique case (nxt)
            S_WR_SETUP:           tmr_len = TMR_W'(SETUP_C);
            S_WR_PULSE:           tmr_len = TMR_W'(PULSE_C);
            S_WR_HOLD, S_RD_HOLD: tmr_len = TMR_W'(HOLD_C);
            S_RD_ACCESS:          tmr_len = TMR_W'(ACC_C);
            default:              tmr_len = TMR_W'(1);
        endcase
    end

    // Request capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_write <= 1'b0;
            rq_addr  <= '0;
            rq_wdata <= '0;
        end else if (accept) begin
            rq_write <= req_write;
            rq_addr  <= req_addr;
            rq_wdata <= req_wdata;
        end
    end

    // Registered RAM-side outputs, decided from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_cs_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_addr <= '0;
            mem_din  <= '0;
        end else begin
            mem_cs_n <= !(nxt == S_WR_SETUP || nxt == S_WR_PULSE || nxt == S_WR_HOLD ||
                          nxt == S_RD_ACCESS || nxt == S_RD_HOLD);
            mem_we_n <= (nxt != S_WR_PULSE);
            if (accept) begin
                mem_addr <= req_addr;
            end
            if (nxt == S_WR_PULSE && state != S_WR_PULSE) begin
                mem_din <= rq_wdata;
            end
        end
    end

    asram_interval #(.CNT_W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .last  (tmr_last)
    );

    asram_recovery #(.ADDR_W(ADDR_W), .RECOV_C(RECOV_C)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_end   (wr_end),
        .wr_addr  (rq_addr),
        .chk_addr (chk_addr),
        .hazard   (rec_hazard)
    );

    asram_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_data  (mem_dout),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // Low-cycle counter for the pulse-width check (R4)
    logic [PCHK_W-1:0] we_low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
        end else if (!mem_we_n) begin
            we_low_cnt <= we_low_cnt + 1'b1;
        end else begin
            we_low_cnt <= '0;
        end
    end

    p_we_needs_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    p_cs_held_at_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_cs_n);

    p_din_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_we_n)) |-> $stable(mem_din));

    p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == PCHK_W'(PULSE_C)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n));

    p_no_early_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_cs_n) && !rq_write) |-> !rec_hazard);

endmodule

// File: tb/sim_asram_seq.sv
`timescale 1ns/1ps
module sim_asram_seq;

    localparam real CLK_NS = 5.0;
    localparam int  SET_C  = 1;                                   // setup 0 ps -> floor of 1
    localparam int  PUL_C  = ((8000 + 4999) / 5000 > (5000 + 4999) / 5000) ?
                             (8000 + 4999) / 5000 : (5000 + 4999) / 5000;
    localparam int  HOLD_C = (2000 + 4999) / 5000;
    localparam int  ACC_C  = (12000 + 4999) / 5000;
    localparam int  REC_C  = (30000 + 4999) / 5000;
    localparam int  HAZ_LAT = REC_C - HOLD_C + ACC_C;             // read issued right after write

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_rdata;
    logic        mem_cs_n;
    logic        mem_we_n;
    logic [15:0] mem_addr;
    logic [3:0]  mem_din;
    logic [3:0]  mem_dout = '0;

    always #2.5 clk = ~clk;

    asram_seq #(
        .ADDR_W(16), .DATA_W(4), .T_CLK_PS(5000), .T_ASET_PS(0),
        .T_PULSE_PS(8000), .T_DSET_PS(5000), .T_HOLD_PS(2000),
        .T_ACC_PS(12000), .T_RECOV_PS(30000)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_din(mem_din), .mem_dout(mem_dout)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] dflt(input logic [15:0] a);
        return a[3:0] ^ a[11:8];
    endfunction

    // ---------------- RAM model ----------------
    logic [3:0]  ram [int];
    logic [3:0]  shadow [int];
    logic [3:0]  exp_q [$];
    realtime     t_chg = 0, t_din = 0, t_wefall = 0, t_werise = -1.0e6;
    logic [15:0] last_wr_a = '0;
    bit          wr_seen = 1'b0;
    logic [15:0] cur_addr = '0;
    logic [3:0]  cur_wdata = '0;

    always @(mem_addr or mem_cs_n) begin
        if (rst_n && wr_seen && ($realtime - t_werise) < 2.0)
            chk(1'b0, "R3", "addr/cs changed inside hold", 32'($realtime - t_werise), 2);
        t_chg = $realtime;
    end

    always @(mem_din) begin
        if (rst_n && wr_seen && ($realtime - t_werise) < 2.0)
            chk(1'b0, "R5", "din changed inside hold", 32'($realtime - t_werise), 2);
        t_din = $realtime;
    end

    always @(negedge mem_we_n) begin
        if (rst_n) begin
            t_wefall = $realtime;
            chk(mem_cs_n === 1'b0, "R9", "cs_n at we fall", 32'(mem_cs_n), 0);
            chk(($realtime - t_chg) >= SET_C * CLK_NS - 0.01, "R3", "addr/cs setup ns",
                32'($realtime - t_chg), 32'(SET_C * 5));
            chk(mem_addr === cur_addr, "R3", "addr at we fall", 32'(mem_addr), 32'(cur_addr));
        end
    end

    always @(posedge mem_we_n) begin
        if (rst_n && mem_cs_n === 1'b0) begin
            chk(($realtime - t_wefall) == PUL_C * CLK_NS, "R4", "we low ns",
                32'($realtime - t_wefall), 32'(PUL_C * 5));
            chk(($realtime - t_din) >= 5.0, "R5", "din setup ns", 32'($realtime - t_din), 5);
            chk(mem_din === cur_wdata, "R5", "din at we rise", 32'(mem_din), 32'(cur_wdata));
            ram[int'(mem_addr)] = mem_din;
            last_wr_a = mem_addr;
            t_werise  = $realtime;
            wr_seen   = 1'b1;
        end
    end

    // Output valid only after access time, and after recovery for the last-written word.
    always @(negedge clk) begin
        realtime tp;
        tp = $realtime + CLK_NS / 2.0;
        if (mem_cs_n !== 1'b0)
            mem_dout = '0;
        else if (mem_we_n !== 1'b1)
            mem_dout = '0;
        else if ((tp - t_chg) >= 12.0 &&
                 (mem_addr != last_wr_a || (tp - t_werise) >= 30.0))
            mem_dout = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : dflt(mem_addr);
        else
            mem_dout = 'x;
    end

    // ---------------- Scoreboard monitor ----------------
    bit prev_rsp = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid === 1'b1) begin
                if (prev_rsp) chk(1'b0, "R6", "rsp_valid longer than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11", "response with no read pending", 1, 0);
                end else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata === e, "R6", "read data", 32'(rsp_rdata), 32'(e));
                end
            end
            prev_rsp = (rsp_valid === 1'b1);
        end
    end

    // ---------------- Driver ----------------
    // Called between edges; returns at the first falling edge where ready is back.
    task automatic do_req(input bit wr, input logic [15:0] a, input logic [3:0] d,
                          input int exp_lat, input string tag);
        int n;
        int lat;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (req_ready !== 1'b1) @(negedge clk);
        cur_addr = a;
        if (wr) begin
            shadow[int'(a)] = d;
            cur_wdata = d;
        end else begin
            exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a));
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
        n = 0; lat = -1;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) chk(req_ready === 1'b0, "R2", "ready after accept", 32'(req_ready), 0);
            if (rsp_valid === 1'b1 && lat < 0) lat = n;
            if (req_ready === 1'b1) break;
        end
        if (wr) begin
            chk(lat < 0, "R11", "write gave response", 32'(lat), 32'hffffffff);
            chk(n == SET_C + PUL_C + HOLD_C + 1, "R10", "write busy cycles", 32'(n),
                32'(SET_C + PUL_C + HOLD_C + 1));
        end else begin
            chk(lat == exp_lat + 1, tag, "read latency", 32'(lat), 32'(exp_lat + 1));
            chk(n == exp_lat + HOLD_C + 1, "R10", "read busy cycles", 32'(n),
                32'(exp_lat + HOLD_C + 1));
        end
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_cs_n === 1'b1 && mem_we_n === 1'b1, "R1", "ram pins in reset",
            {30'd0, mem_cs_n, mem_we_n}, 3);
        rst_n = 1'b1;
        idle(2);
        chk(mem_cs_n === 1'b1, "R1", "cs_n after reset", 32'(mem_cs_n), 1);
        chk(mem_we_n === 1'b1, "R1", "we_n after reset", 32'(mem_we_n), 1);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
        chk(req_ready === 1'b1, "R1", "ready after reset", 32'(req_ready), 1);

        // Write, then an immediate read elsewhere: no delay (R8)
        do_req(1'b1, 16'h1234, 4'hA, 0, "R5");
        do_req(1'b0, 16'h0040, 4'h0, ACC_C, "R8");
        idle(10);
        do_req(1'b0, 16'h1234, 4'h0, ACC_C, "R6");

        // Write then immediate read of the same word: recovery wait (R7)
        do_req(1'b1, 16'h1234, 4'h5, 0, "R5");
        do_req(1'b0, 16'h1234, 4'h0, HAZ_LAT, "R7");

        // Address and data extremes
        do_req(1'b1, 16'h0000, 4'hF, 0, "R5");
        do_req(1'b1, 16'hFFFF, 4'h0, 0, "R5");
        do_req(1'b0, 16'hFFFF, 4'h0, HAZ_LAT, "R7");
        do_req(1'b0, 16'h0000, 4'h0, ACC_C, "R6");

        // Burst of writes, then read-back of each word
        for (int i = 0; i < 8; i++)
            do_req(1'b1, 16'(i * 16'h1111 + 3), 4'(i * 3 + 1), 0, "R5");
        for (int i = 0; i < 8; i++)
            do_req(1'b0, 16'(i * 16'h1111 + 3), 4'h0, ACC_C, "R6");

        // Same word written twice back to back, then read after the window
        do_req(1'b1, 16'h0A0A, 4'h3, 0, "R5");
        do_req(1'b1, 16'h0A0A, 4'hC, 0, "R5");
        idle(8);
        do_req(1'b0, 16'h0A0A, 4'h0, ACC_C, "R6");

        idle(4);
        chk(exp_q.size() == 0, "R6", "reads left unanswered", 32'(exp_q.size()), 0);
        chk(mem_cs_n === 1'b1, "R10", "cs_n while idle", 32'(mem_cs_n), 1);
        report();
        $finish;
    end

endmodule